// File: doc/BRIEF.md
# Noise-Adaptive Horizontal Phase Detector Gate Controller

This block sits next to the horizontal phase detector of a line-locked video timebase. It takes the line counter position and three condition flags: signal noisy, line oscillator locked and vertical retrace active. From them it decides, clock by clock, whether the phase detector may compare during this part of the line, and which charge-pump current it should drive. The analog noise detector and the charge pump are outside the block. The block only produces the enable and a 2-bit current code.

The behaviour follows the operating condition. With a clean signal and a locked loop, the detector runs over the whole line during active scan. During vertical retrace, when copy-protection pulses can appear, it only looks inside a wide window around the expected sync edge and uses a raised current, so that head-switch phase errors are pulled in quickly. With a noisy signal and a locked loop, a narrow window with a low current is used for the whole field. An unlocked loop gets no gating at all, so that it can acquire. The window is centred on line position 0, which is the expected sync front edge, so it wraps across the end of the line. The flags are sampled once per line, at the point half a line away from the sync edge. A window is therefore never cut short by a change of mode.

Top module: `hpd_gate_ctrl`

## Requirements
- R1: While reset is asserted, and until the first flag sample, the outputs show the unlocked, scan condition: gate enable 1 and current code 2.
- R2: The three flags are captured only in the cycle where line_pos equals LINE_CLKS/2 (429 by default). The captured condition governs outputs from that position until the next capture. Flag changes at any other position have no effect before then.
- R3: The current code is 0 = off, 1 = 30 µA, 2 = 180 µA, 3 = 270 µA. When not locked, the gate is enabled at every position, with code 2 during scan and code 3 during retrace.
- R4: When locked and noisy, in both scan and retrace, the gate is enabled only for the 77 positions at signed offset -38..+38 from position 0, with code 1.
- R5: When locked and not noisy during scan, the gate is enabled at every position with code 2.
- R6: When locked and not noisy during retrace, the gate is enabled only for the 162 positions at signed offset -81..+80 from position 0, with code 3.
- R7: Whenever the gate is not enabled, the current code is 0. Whenever it is enabled, the code is non-zero.
- R8: Outputs are registered. The values after a clock edge correspond to the line_pos value and the captured condition sampled at that edge.
- R9: The noisy flag has no effect while the loop is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pos | input | POS_W (10) | Line counter, 0 = expected sync front edge |
| noisy | input | 1 | Weak/noisy signal flag |
| locked | input | 1 | Line oscillator coincidence (locked) flag |
| v_retrace | input | 1 | Vertical retrace active |
| pd_gate_en | output | 1 | Phase detector enable |
| pump_sel | output | 2 | Charge-pump current code |

## Verification
The hardest case to reach from the ports is a flag change in the middle of a line, while a wrapped window is partly through. The block must keep the previous condition right up to the capture point and then switch cleanly. The stimulus walks the line counter through complete lines. It changes the flags at several positions, including inside the tail of a window, just before the capture point and just after it. A scoreboard model that knows only the capture rule predicts every output cycle. It also steps through all three conditions in both scan and retrace, so that each window boundary at offsets -38/+38 and -81/+80 is hit from both sides.

// File: rtl/hpd_gate_pkg.sv
package hpd_gate_pkg;

  typedef enum logic [1:0] {
    COND_UNLOCKED = 2'd0,
    COND_WEAK     = 2'd1,
    COND_STRONG   = 2'd2
  } sig_cond_e;

  typedef enum logic [1:0] {
    PUMP_OFF  = 2'd0,
    PUMP_LOW  = 2'd1,
    PUMP_MID  = 2'd2,
    PUMP_HIGH = 2'd3
  } pump_code_e;

  typedef struct packed {
    sig_cond_e cond;
    logic      retrace;
  } line_mode_t;

  localparam line_mode_t MODE_RESET = '{cond: COND_UNLOCKED, retrace: 1'b0};

  // Map the two loop-condition flags onto a signal condition.
  function automatic sig_cond_e classify(input logic is_locked, input logic is_noisy);
    if (!is_locked)     return COND_UNLOCKED;
    else if (is_noisy)  return COND_WEAK;
    else                return COND_STRONG;
  endfunction

  // A window of 'width' positions centred on position 0 of a 'len' long line.
  // The leading half sits before the wrap, the trailing half after it.
  function automatic logic near_edge(input int unsigned pos,
                                     input int unsigned len,
                                     input int unsigned width);
    int unsigned lead;
    int unsigned trail;
    lead  = width / 2;
    trail = width - 1 - lead;
    return ((pos + lead) >= len) || (pos <= trail);
  endfunction

endpackage

// File: rtl/pdg_mode_hold.sv
module pdg_mode_hold
  import hpd_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       noisy,
  input  logic       locked,
  input  logic       v_retrace,
  output line_mode_t mode_eff,
  output line_mode_t mode_held
);

  line_mode_t mode_new;

  always_comb begin
    mode_new.cond    = classify(locked, noisy);
    mode_new.retrace = v_retrace;
  end

  assign mode_eff = capture ? mode_new : mode_held;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_held <= MODE_RESET;
    else        mode_held <= mode_eff;
  end

endmodule

// File: rtl/pdg_window.sv
module pdg_window
  import hpd_gate_pkg::*;
#(
  parameter int LINE_CLKS   = 858,
  parameter int NARROW_CLKS = 77,
  parameter int WIDE_CLKS   = 162,
  localparam int POS_W      = $clog2(LINE_CLKS)
) (
  input  logic [POS_W-1:0] pos,
  output logic             hit_narrow,
  output logic             hit_wide
);

  localparam int NWIN = 2;
  logic [NWIN-1:0] hit;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int WIDTH = (g == 0) ? NARROW_CLKS : WIDE_CLKS;
    assign hit[g] = near_edge(32'(pos), LINE_CLKS, WIDTH);
  end

  assign hit_narrow = hit[0];
  assign hit_wide   = hit[1];

endmodule

// File: rtl/pdg_policy.sv
module pdg_policy
  import hpd_gate_pkg::*;
(
  input  line_mode_t mode,
  input  logic       hit_narrow,
  input  logic       hit_wide,
  output logic       gate_open,
  output pump_code_e pump
);

  always_comb begin
    gate_open = 1'b1;
    pump      = PUMP_MID;
    unique case (mode.cond)
      COND_UNLOCKED: begin
        gate_open = 1'b1;
        pump      = mode.retrace ? PUMP_HIGH : PUMP_MID;
      end
      COND_WEAK: begin
        gate_open = hit_narrow;
        pump      = hit_narrow ? PUMP_LOW : PUMP_OFF;
      end
      COND_STRONG: begin
        if (mode.retrace) begin
          gate_open = hit_wide;
          pump      = hit_wide ? PUMP_HIGH : PUMP_OFF;
        end else begin
          gate_open = 1'b1;
          pump      = PUMP_MID;
        end
      end
      default: begin
        gate_open = 1'b1;
        pump      = PUMP_MID;
      end
    endcase
  end

endmodule

// File: rtl/hpd_gate_ctrl.sv
module hpd_gate_ctrl
  import hpd_gate_pkg::*;
#(
  parameter int LINE_CLKS   = 858,
  parameter int NARROW_CLKS = 77,
  parameter int WIDE_CLKS   = 162,
  localparam int POS_W      = $clog2(LINE_CLKS),
  localparam int UPD_POS    = LINE_CLKS / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] line_pos,
  input  logic             noisy,
  input  logic             locked,
  input  logic             v_retrace,
  output logic             pd_gate_en,
  output logic [1:0]       pump_sel
);

  // Named internal events for the checker.
  logic       upd_evt;
  line_mode_t mode_eff;
  line_mode_t mode_held;
  line_mode_t mode_out_q;
  logic       hit_narrow;
  logic       hit_wide;
  logic       gate_d;
  pump_code_e pump_d;
  logic       gate_q;
  pump_code_e pump_q;

  assign upd_evt = (line_pos == POS_W'(UPD_POS));

  pdg_mode_hold u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (upd_evt),
    .noisy     (noisy),
    .locked    (locked),
    .v_retrace (v_retrace),
    .mode_eff  (mode_eff),
    .mode_held (mode_held)
  );

  pdg_window #(
    .LINE_CLKS   (LINE_CLKS),
    .NARROW_CLKS (NARROW_CLKS),
    .WIDE_CLKS   (WIDE_CLKS)
  ) u_win (
    .pos        (line_pos),
    .hit_narrow (hit_narrow),
    .hit_wide   (hit_wide)
  );

  pdg_policy u_pol (
    .mode       (mode_eff),
    .hit_narrow (hit_narrow),
    .hit_wide   (hit_wide),
    .gate_open  (gate_d),
    .pump       (pump_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q     <= 1'b1;
      pump_q     <= PUMP_MID;
      mode_out_q <= MODE_RESET;
    end else begin
      gate_q     <= gate_d;
      pump_q     <= pump_d;
      mode_out_q <= mode_eff;
    end
  end

  assign pd_gate_en = gate_q;
  assign pump_sel   = pump_q;

endmodule

// File: rtl/hpd_gate_ctrl_chk.sv
module hpd_gate_ctrl_chk
  import hpd_gate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pd_gate_en,
  input logic [1:0] pump_sel,
  input line_mode_t mode_out,
  input line_mode_t mode_held,
  input logic       upd_evt
);

  p_closed_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_gate_en |-> pump_sel == 2'd0);

  p_open_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_gate_en |-> pump_sel != 2'd0);

  p_unlocked_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out.cond == COND_UNLOCKED) |->
      (pd_gate_en && pump_sel == (mode_out.retrace ? 2'd3 : 2'd2)));

  p_weak_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out.cond == COND_WEAK) |-> (pump_sel == 2'd0 || pump_sel == 2'd1));

  p_strong_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out.cond == COND_STRONG && !mode_out.retrace) |->
      (pd_gate_en && pump_sel == 2'd2));

  p_strong_retrace_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out.cond == COND_STRONG && mode_out.retrace && pd_gate_en) |->
      pump_sel == 2'd3);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(mode_held));

endmodule

bind hpd_gate_ctrl hpd_gate_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_gate_en (pd_gate_en),
  .pump_sel   (pump_sel),
  .mode_out   (mode_out_q),
  .mode_held  (mode_held),
  .upd_evt    (upd_evt)
);

// File: tb/sim_hpd_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hpd_gate_ctrl;

  localparam int LEN   = 858;
  localparam int PW    = 10;
  localparam int CAPAT = 429;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] line_pos = '0;
  logic          noisy = 1'b0;
  logic          locked = 1'b0;
  logic          v_retrace = 1'b0;
  logic          pd_gate_en;
  logic [1:0]    pump_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  bit         q_en[$];
  bit [1:0]   q_cur[$];
  string      q_tag[$];

  // Bench-side captured condition.
  bit m_locked = 1'b0;
  bit m_noisy  = 1'b0;
  bit m_ret    = 1'b0;
  string tag_over = "";

  always #5 clk = ~clk;

  hpd_gate_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pos   (line_pos),
    .noisy      (noisy),
    .locked     (locked),
    .v_retrace  (v_retrace),
    .pd_gate_en (pd_gate_en),
    .pump_sel   (pump_sel)
  );

  task automatic check(input string tag, input bit en, input bit [1:0] cur);
    n_checks++;
    if (pd_gate_en !== en || pump_sel !== cur) begin
      n_fail++;
      $display("FAIL %s pos-seq en=%0b cur=%0d expected en=%0b cur=%0d",
               tag, pd_gate_en, pump_sel, en, cur);
    end
  endtask

  // Drive one position and push the expected registered result.
  task automatic drive_pos(input int p);
    int off;
    bit en;
    bit [1:0] cur;
    string tag;
    @(negedge clk);
    line_pos = PW'(p);
    if (p == CAPAT) begin
      m_locked = locked; m_noisy = noisy; m_ret = v_retrace;
    end
    off = (p < LEN / 2) ? p : p - LEN;
    if (!m_locked) begin
      en = 1'b1; cur = m_ret ? 2'd3 : 2'd2;
      tag = m_noisy ? "R9" : "R3";
    end else if (m_noisy) begin
      en = (off >= -38 && off <= 38);
      cur = en ? 2'd1 : 2'd0;
      tag = en ? "R4" : "R7";
    end else if (!m_ret) begin
      en = 1'b1; cur = 2'd2; tag = "R5";
    end else begin
      en = (off >= -81 && off <= 80);
      cur = en ? 2'd3 : 2'd0;
      tag = en ? "R6" : "R7";
    end
    if (tag_over != "") tag = {tag_over, "/", tag};
    q_en.push_back(en);
    q_cur.push_back(cur);
    q_tag.push_back({tag, "/R8"});
  endtask

  // One full line; flags switch to (l,w,r) when position chg_at is driven.
  task automatic run_line(input bit l, input bit w, input bit r, input int chg_at);
    for (int p = 0; p < LEN; p++) begin
      if (p == chg_at) begin
        @(negedge clk);
        locked = l; noisy = w; v_retrace = r;
        line_pos = PW'(p);
        q_en.push_back(q_en.size() > 0 ? q_en[$] : 1'b1);
        q_cur.push_back(q_cur.size() > 0 ? q_cur[$] : 2'd2);
        q_tag.push_back("skip");
      end
      drive_pos(p);
    end
  endtask

  // Monitor: compares one item per cycle, away from the clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_en.size() > 0) begin
        bit e; bit [1:0] c; string t;
        e = q_en.pop_front(); c = q_cur.pop_front(); t = q_tag.pop_front();
        if (t != "skip") check(t, e, c);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b1, 2'd2);
    locked = 1'b1; noisy = 1'b1; v_retrace = 1'b1;
    @(negedge clk);
    check("R1", 1'b1, 2'd2);
    locked = 1'b0; noisy = 1'b0; v_retrace = 1'b0;
    rst_n = 1'b1;
    // R1: before the first capture, the reset condition persists.
    for (int p = 0; p < 40; p++) drive_pos(p);
    // R3 unlocked scan, then retrace
    run_line(0, 0, 0, 0);
    run_line(0, 0, 1, 0);
    // R9 noisy while unlocked
    run_line(0, 1, 1, 0);
    run_line(0, 1, 0, 0);
    // R4 weak locked, scan and retrace
    run_line(1, 1, 0, 0);
    run_line(1, 1, 1, 0);
    // R5 and R6 strong locked
    run_line(1, 0, 0, 0);
    run_line(1, 0, 1, 0);
    // R2: changes inside a window tail, just before and just after capture
    tag_over = "R2";
    run_line(1, 1, 0, 820);
    run_line(1, 0, 1, 428);
    run_line(0, 0, 0, 430);
    run_line(1, 0, 1, 30);
    run_line(1, 1, 1, 0);
    tag_over = "";
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule